// File: doc/BRIEF.md
# Per-Channel Output Selector with Connection Store

This block is the playout side of a time-slot switch. It keeps one connection entry for each outgoing channel of a parallel stream. Each entry has two bytes: a low byte and a high byte made of mode flags. One channel is played per clock slot. For each slot the block works out what the channel carries. The choices are a byte fetched from an external data memory at a programmed source address, a literal byte stored by the host, or the receive-side byte passed straight through. With that byte it produces a drive-enable flag and a nibble of per-channel control pins.

A host loads entries through a simple write strobe that has its own address and plane select. Playout is paced by the slot clock and cannot be stalled, so neither side has a ready signal and there is no back-pressure. The data memory is expected to return its byte one clock after the address is presented. For that reason every channel's result appears one slot after its entry is read. A `frame_sync` pulse realigns the channel counter to channel 0.

Top module: `cm_out_selector`

## Requirements
- R1: While `rst_n` is low, `out_data`, `out_oe` and `ctl_pins` are all 0. After release, the first slot reads channel 0.
- R2: The high byte is laid out from bit 7 down as: drive enable, pass-through, literal, control 1, control 2 / address bit 11, control 3 / address bit 10, address bit 9, address bit 8.
- R3: When the literal bit (bit 5) is 1, `out_data` equals the entry's low byte in the slot after the entry is read.
- R4: In modes 0 to 2, `dm_addr` during the read slot is {3'b000, high bit 0, low byte}. If neither literal nor an honoured pass-through is set, `out_data` in the next slot is the data memory's reply.
- R5: In mode 3, `dm_addr` is {high bits 3..0, low byte}, a 12-bit source address.
- R6: In modes 0 and 1, pass-through (bit 6) with literal 0 makes `out_data` equal `rx_data` in the output slot.
- R7: A set literal bit overrides a set pass-through bit.
- R8: In modes 2 and 3 the pass-through bit has no effect, and the channel carries switched data.
- R9: In the output slot, `out_oe` equals bit 7. `ctl_pins` is {control 3, control 2, control 1, drive enable}, taken from bits 2, 3, 4 and 7.
- R10: In mode 3, `ctl_pins[3:2]` are 0.
- R11: A `frame_sync` in one clock makes the next clock read channel 0. Channels then advance by one per clock and wrap from NUM_CH-1 to 0.
- R12: A host write lands at the clock edge. A write to the entry being read in that same slot leaves this slot's output unchanged, and the new value takes effect on the next read of that channel, one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Timing mode 0..3 |
| frame_sync | input | 1 | Realigns playout to channel 0 on the next clock |
| wr_en | input | 1 | Host write strobe |
| wr_hi | input | 1 | Plane select: 1 high byte, 0 low byte |
| wr_ch | input | CH_W | Channel written |
| wr_data | input | 8 | Byte written |
| dm_addr | output | 12 | Data memory source address for the channel being read |
| dm_rdata | input | 8 | Data memory reply, one clock after `dm_addr` |
| rx_data | input | 8 | Receive-side byte for pass-through |
| out_data | output | 8 | Byte carried by the current output channel |
| out_oe | output | 1 | Drive enable for the current output channel |
| ctl_pins | output | 4 | Per-channel control pins |

## Verification
The bench builds the block with NUM_CH = 8. At that size a full frame is only eight slots, so runs that cross the wrap from the last channel back to 0, runs that realign mid-frame, and a write aimed at the exact slot being read all fit into a few short scenarios. Every timing mode is exercised against the same small table of entries, so the priority between literal, pass-through and switched data is compared directly across modes.

// File: rtl/cm_pkg.sv
`timescale 1ns/1ps
package cm_pkg;
  localparam int BYTE_W = 8;
  localparam int SRC_AW = 12;

  // mode 3 = wide parallel-source addressing
  localparam logic [1:0] MODE_WIDE = 2'd3;

  typedef struct packed {
    logic oe;
    logic pass;
    logic lit;
    logic c1;
    logic c2_a11;
    logic c3_a10;
    logic a9;
    logic a8;
  } cm_hi_t;

  typedef enum logic [1:0] {SRC_DMEM = 2'd0, SRC_LIT = 2'd1, SRC_RX = 2'd2} src_e;
endpackage

// File: rtl/cm_store.sv
`timescale 1ns/1ps
module cm_store #(
  parameter int NUM_CH = 1024,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic                      wr_hi,
  input  logic [CH_W-1:0]           wr_ch,
  input  logic [cm_pkg::BYTE_W-1:0] wr_data,
  input  logic [CH_W-1:0]           rd_ch,
  output logic [cm_pkg::BYTE_W-1:0] rd_lo,
  output logic [cm_pkg::BYTE_W-1:0] rd_hi
);
  import cm_pkg::*;

  logic [BYTE_W-1:0] plane_rd [2];
  logic              in_range;

  assign in_range = (32'(wr_ch) < NUM_CH);

  // plane 0 = low byte, plane 1 = high byte
  for (genvar p = 0; p < 2; p++) begin : g_plane
    logic [BYTE_W-1:0] mem [NUM_CH];
    logic              we;
    assign we = wr_en && in_range && (wr_hi == p[0]);
    always_ff @(posedge clk) begin
      if (we) mem[wr_ch] <= wr_data;
    end
    assign plane_rd[p] = mem[rd_ch];
  end

  assign rd_lo = plane_rd[0];
  assign rd_hi = plane_rd[1];
endmodule

// File: rtl/cm_sequencer.sv
`timescale 1ns/1ps
module cm_sequencer #(
  parameter int NUM_CH = 1024,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_sync,
  output logic [CH_W-1:0] ch
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ch_q <= '0;
    else if (frame_sync || ch_q == LAST) ch_q <= '0;
    else                               ch_q <= ch_q + 1'b1;
  end

  assign ch = ch_q;

  // R11
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (ch_q == '0));
  // R11
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && ch_q == LAST) |=> (ch_q == '0));
  // R11
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && ch_q != LAST) |=> (ch_q == CH_W'($past(ch_q) + 1'b1)));
endmodule

// File: rtl/cm_select.sv
`timescale 1ns/1ps
module cm_select (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode,
  input  logic [cm_pkg::BYTE_W-1:0] rd_lo,
  input  cm_pkg::cm_hi_t            rd_hi,
  output logic [cm_pkg::SRC_AW-1:0] dm_addr,
  input  logic [cm_pkg::BYTE_W-1:0] dm_rdata,
  input  logic [cm_pkg::BYTE_W-1:0] rx_data,
  output logic [cm_pkg::BYTE_W-1:0] out_data,
  output logic                      out_oe,
  output logic [3:0]                ctl_pins
);
  import cm_pkg::*;

  logic              wide;
  logic              pass_ok;
  src_e              src_d, src_q;
  logic [BYTE_W-1:0] lit_q;
  logic              oe_q;
  logic [3:0]        ctl_d, ctl_q;

  assign wide    = (mode == MODE_WIDE);
  // pass-through only honoured in modes 0 and 1
  assign pass_ok = rd_hi.pass && !mode[1];

  always_comb begin
    if (wide) dm_addr = {rd_hi.c2_a11, rd_hi.c3_a10, rd_hi.a9, rd_hi.a8, rd_lo};
    else      dm_addr = {3'b000, rd_hi.a8, rd_lo};
  end

  always_comb begin
    if (rd_hi.lit)    src_d = SRC_LIT;
    else if (pass_ok) src_d = SRC_RX;
    else              src_d = SRC_DMEM;
  end

  assign ctl_d = {wide ? 1'b0 : rd_hi.c3_a10,
                  wide ? 1'b0 : rd_hi.c2_a11,
                  rd_hi.c1,
                  rd_hi.oe};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_LIT;
      lit_q <= '0;
      oe_q  <= 1'b0;
      ctl_q <= '0;
    end else begin
      src_q <= src_d;
      lit_q <= rd_lo;
      oe_q  <= rd_hi.oe;
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_LIT: out_data = lit_q;
      SRC_RX:  out_data = rx_data;
      default: out_data = dm_rdata;
    endcase
  end

  assign out_oe   = oe_q;
  assign ctl_pins = ctl_q;

  // R3
  lit_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi.lit |=> (out_data == $past(rd_lo)));
  // R7
  lit_over_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi.lit && rd_hi.pass) |=> (out_data != rx_data || out_data == $past(rd_lo)));
  // R8
  pass_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hi.lit && mode[1]) |=> (out_data == dm_rdata));
  // R9
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi.oe |=> (out_oe && ctl_pins[0]));
  // R10
  wide_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WIDE) |=> (ctl_pins[3:2] == 2'b00));
endmodule

// File: rtl/cm_out_selector.sv
`timescale 1ns/1ps
module cm_out_selector #(
  parameter int NUM_CH = 1024,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            frame_sync,
  input  logic            wr_en,
  input  logic            wr_hi,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [7:0]      wr_data,
  output logic [11:0]     dm_addr,
  input  logic [7:0]      dm_rdata,
  input  logic [7:0]      rx_data,
  output logic [7:0]      out_data,
  output logic            out_oe,
  output logic [3:0]      ctl_pins
);
  import cm_pkg::*;

  logic [CH_W-1:0]   rd_ch;
  logic [BYTE_W-1:0] rd_lo;
  logic [BYTE_W-1:0] rd_hi_raw;
  cm_hi_t            rd_hi;

  cm_sequencer #(.NUM_CH(NUM_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ch(rd_ch)
  );

  cm_store #(.NUM_CH(NUM_CH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_hi(wr_hi), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_lo(rd_lo), .rd_hi(rd_hi_raw)
  );

  assign rd_hi = cm_hi_t'(rd_hi_raw);

  cm_select u_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .dm_addr(dm_addr), .dm_rdata(dm_rdata), .rx_data(rx_data),
    .out_data(out_data), .out_oe(out_oe), .ctl_pins(ctl_pins)
  );
endmodule

// File: tb/cm_out_selector_test.sv
`timescale 1ns/1ps
module cm_out_selector_test;
  localparam int N  = 8;
  localparam int CW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          frame_sync = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_hi = 1'b0;
  logic [CW-1:0] wr_ch = '0;
  logic [7:0]    wr_data = '0;
  logic [11:0]   dm_addr;
  logic [7:0]    dm_rdata = '0;
  logic [7:0]    rx_data = 8'hC3;
  logic [7:0]    out_data;
  logic          out_oe;
  logic [3:0]    ctl_pins;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] lo_m [N];
  logic [7:0] hi_m [N];

  always #2.5 clk = ~clk;

  cm_out_selector #(.NUM_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .frame_sync(frame_sync),
    .wr_en(wr_en), .wr_hi(wr_hi), .wr_ch(wr_ch), .wr_data(wr_data),
    .dm_addr(dm_addr), .dm_rdata(dm_rdata), .rx_data(rx_data),
    .out_data(out_data), .out_oe(out_oe), .ctl_pins(ctl_pins)
  );

  function automatic logic [7:0] dm_fn(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  // bench model of the data memory: one clock of read latency
  always_ff @(posedge clk) dm_rdata <= dm_fn(dm_addr);

  function automatic logic [11:0] exp_addr(input int c);
    if (mode == 2'd3) return {hi_m[c][3:0], lo_m[c]};
    return {3'b000, hi_m[c][0], lo_m[c]};
  endfunction

  function automatic logic [7:0] exp_out(input int c);
    if (hi_m[c][5]) return lo_m[c];
    if (hi_m[c][6] && mode < 2'd2) return rx_data;
    return dm_fn(exp_addr(c));
  endfunction

  function automatic logic [3:0] exp_ctl(input int c);
    logic w;
    w = (mode == 2'd3);
    return {w ? 1'b0 : hi_m[c][2], w ? 1'b0 : hi_m[c][3], hi_m[c][4], hi_m[c][7]};
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input int c, input logic hi, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_ch = CW'(c); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (hi) hi_m[c] = d; else lo_m[c] = d;
  endtask

  task automatic load(input int c, input logic [7:0] lo, input logic [7:0] hi);
    wr(c, 1'b0, lo);
    wr(c, 1'b1, hi);
  endtask

  // pulse sync, then check `slots` channels in order
  task automatic play(input string tag_d, input string tag_c, input int slots);
    @(negedge clk) frame_sync = 1'b1;
    @(negedge clk) frame_sync = 1'b0;
    for (int k = 0; k < slots; k++) begin
      int c;
      c = k % N;
      check(tag_d, "dm_addr", int'(dm_addr), int'(exp_addr(c)));
      @(negedge clk);
      check(tag_d, "out_data", int'(out_data), int'(exp_out(c)));
      check(tag_c, "out_oe", int'(out_oe), int'(hi_m[c][7]));
      check(tag_c, "ctl_pins", int'(ctl_pins), int'(exp_ctl(c)));
    end
  endtask

  task automatic t_reset;
    // entries loaded while reset is held; outputs stay quiet (R1)
    for (int c = 0; c < N; c++) load(c, 8'(8'h10 + c), 8'h80 | 8'(c[0]));
    check("R1", "out_data", int'(out_data), 0);
    check("R1", "out_oe", int'(out_oe), 0);
    check("R1", "ctl_pins", int'(ctl_pins), 0);
    @(negedge clk) rst_n = 1'b1;
    #0.5;
    check("R1", "first read addr", int'(dm_addr), int'(exp_addr(0)));
  endtask

  task automatic t_literal;
    mode = 2'd0;
    for (int c = 0; c < N; c++) load(c, 8'(8'hA0 + 7 * c), 8'h20 | (c[0] ? 8'h80 : 8'h00));
    play("R3", "R2", N);
  endtask

  task automatic t_switched;
    mode = 2'd2;
    for (int c = 0; c < N; c++) load(c, 8'(8'h40 + 3 * c), 8'h80 | 8'(c[0]));
    play("R4", "R2", N);
    mode = 2'd1;
    play("R4", "R9", N);
  endtask

  task automatic t_wide;
    mode = 2'd3;
    for (int c = 0; c < N; c++) load(c, 8'(17 * c), {4'b1000, 4'(c + 5)} | 8'h1C);
    play("R5", "R10", N);
  endtask

  task automatic t_pass;
    for (int c = 0; c < N; c++)
      load(c, 8'(8'h70 + c), c[0] ? 8'hE0 : 8'hC0);
    mode = 2'd0; rx_data = 8'h3C;
    play("R6 R7", "R9", N);
    mode = 2'd1; rx_data = 8'h96;
    play("R6 R7", "R9", N);
    mode = 2'd2;
    play("R8", "R9", N);
    mode = 2'd3;
    play("R8", "R10", N);
  endtask

  task automatic t_ctl;
    mode = 2'd0;
    for (int c = 0; c < N; c++)
      load(c, 8'(c), {c[0], 1'b0, 1'b1, c[1], c[2], ~c[0], 2'b00});
    play("R3", "R9 R2", N);
  endtask

  task automatic t_wrap;
    mode = 2'd2;
    for (int c = 0; c < N; c++) load(c, 8'(8'h33 + 5 * c), 8'h80 | 8'(~c[1]));
    play("R11", "R11", 2 * N + 3);
    play("R11", "R11", 3);
  endtask

  task automatic t_same_slot_write;
    mode = 2'd0;
    for (int c = 0; c < N; c++) load(c, 8'(8'h50 + c), 8'hA0);
    load(3, 8'h11, 8'hA0);
    @(negedge clk) frame_sync = 1'b1;
    @(negedge clk) frame_sync = 1'b0;
    repeat (3) @(negedge clk);
    // channel 3 is read in this slot; write it now
    wr_en = 1'b1; wr_hi = 1'b0; wr_ch = CW'(3); wr_data = 8'h22;
    @(negedge clk);
    wr_en = 1'b0;
    check("R12", "old byte kept", int'(out_data), 'h11);
    lo_m[3] = 8'h22;
    play("R12", "R12", N);
  endtask

  initial begin
    t_reset();
    t_literal();
    t_switched();
    t_wide();
    t_pass();
    t_ctl();
    t_wrap();
    t_same_slot_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule